// File: doc/BRIEF.md
# Snooping Memory-Side Coherence Controller

This block sits next to the shared backing store on a totally ordered snooping bus. It keeps one small state machine per cache block, separate from the state machines in the core caches. Every ordered request on the bus is presented to it together with the requesting core's index. From the block's state it decides whether the backing store owns the data and must answer, or whether a core holds a modified copy and will supply the data itself.

When a core gives up a modified block, either because another core wants to read it or because the owner evicts it, the controller waits in a transient state until the core's writeback data arrives. It then stores the data and takes ownership back. A per-block flag records that the block has been shared since the last write request. A read that finds the flag clear is granted an exclusive copy. From then on the reader is treated as the owner, because it may silently upgrade to a writable copy. Blocks are 64 bytes and the backing store is a plain array, cleared to zero at reset.

Top module: `llc_snoop_ctrl`

## Requirements
- R1: After reset every block is memory-owned with its sharer flag clear, the store holds zero, and `resp_valid_o` is low.
- R2: A read (`req_type_i` 2'b00) or write request (2'b01) to a memory-owned block produces, on the next clock edge, `resp_valid_o` with `resp_core_o`/`resp_addr_o` equal to the request's and `resp_data_o` equal to the stored block.
- R3: A read response carries `resp_excl_o`=1 when the block's sharer flag is clear, and the reader then becomes the recorded owner. With the flag set, it carries 0 and the block stays shared.
- R4: A read to a core-owned block gets no response from the controller and puts the block in a wait state. Writeback data from the owner is stored and leaves the block shared with its sharer flag set.
- R5: A write request answered by the controller carries `resp_excl_o`=1. Any write request records the requester as owner and clears the sharer flag. A write request to a core-owned block gets no response.
- R6: An eviction request (2'b10) from the recorded owner puts the block in a wait state. The owner's writeback data is then stored and the block returns to memory ownership with the flag clear.
- R7: An eviction request from a core that is not the recorded owner, or to a memory-owned block, is ignored. Request type 2'b11 is ignored.
- R8: Any request to a block in a wait state is dropped: no response, and no change to state or owner.
- R9: Writeback data (`wb_valid_i`) is accepted only when its block is waiting and `wb_core_i` is the recorded owner. Otherwise it is dropped and the store is unchanged.
- R10: `sharer_present_o` shows, combinationally, the sharer flag of the block addressed by `req_addr_i`.
- R11: Blocks are independent: a request to one block leaves the state and data of every other block unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Ordered bus request present this cycle |
| req_type_i | input | 2 | 00 read, 01 write, 10 eviction, 11 reserved |
| req_core_i | input | 2 | Requesting core index |
| req_addr_i | input | 3 | Block index |
| wb_valid_i | input | 1 | Writeback data present |
| wb_core_i | input | 2 | Core sending the writeback |
| wb_addr_i | input | 3 | Block index of the writeback |
| wb_data_i | input | 512 | Writeback block data |
| resp_valid_o | output | 1 | Controller data response |
| resp_core_o | output | 2 | Destination core of the response |
| resp_addr_o | output | 3 | Block index of the response |
| resp_excl_o | output | 1 | Response grants an exclusive copy |
| resp_data_o | output | 512 | Response block data |
| sharer_present_o | output | 1 | Sharer flag of the block at `req_addr_i` |

## Verification
On every cycle the assertions check the per-block transitions: write requests record the requester as owner and clear the flag, completed downgrades leave the block shared, owner evictions enter the wait state, and waiting blocks hold still unless the owner's data arrives. They also check that a response follows only a request and that at most one block takes a writeback. What the bus sees only the directed scenarios can show: the stored data coming back after a downgrade or eviction, the exclusive bit flipping with the flag, and stray evictions or writebacks leaving later responses unchanged.

// File: rtl/llc_snoop_pkg.sv
package llc_snoop_pkg;
  typedef enum logic [1:0] {
    REQ_GETS = 2'b00,
    REQ_GETM = 2'b01,
    REQ_PUTM = 2'b10,
    REQ_RSVD = 2'b11
  } bus_req_e;

  typedef enum logic [2:0] {
    BLK_I      = 3'd0,
    BLK_S      = 3'd1,
    BLK_M      = 3'd2,
    BLK_IORS_D = 3'd3,
    BLK_MI_D   = 3'd4
  } blk_state_e;
endpackage

// File: rtl/llc_snoop_blk.sv
module llc_snoop_blk
  import llc_snoop_pkg::*;
#(
  parameter int CORE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_hit_i,
  input  bus_req_e          req_type_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic              wb_hit_i,
  input  logic [CORE_W-1:0] wb_core_i,
  output logic              respond_o,
  output logic              excl_o,
  output logic              sharer_o,
  output logic              wb_take_o,
  output logic              waiting_o
);
  blk_state_e        state_q, state_d;
  logic [CORE_W-1:0] owner_q, owner_d;
  logic              sharer_q, sharer_d;
  logic              mem_owns, is_gets, is_getm, is_putm;

  assign mem_owns  = (state_q == BLK_I) || (state_q == BLK_S);
  assign waiting_o = (state_q == BLK_IORS_D) || (state_q == BLK_MI_D);
  assign is_gets   = req_hit_i && (req_type_i == REQ_GETS);
  assign is_getm   = req_hit_i && (req_type_i == REQ_GETM);
  assign is_putm   = req_hit_i && (req_type_i == REQ_PUTM);
  assign respond_o = mem_owns && (is_gets || is_getm);
  assign excl_o    = is_getm || !sharer_q;
  assign sharer_o  = sharer_q;
  assign wb_take_o = wb_hit_i && waiting_o && (wb_core_i == owner_q);

  always_comb begin
    state_d  = state_q;
    owner_d  = owner_q;
    sharer_d = sharer_q;
    unique case (state_q)
      BLK_I, BLK_S: begin
        if (is_getm) begin
          state_d  = BLK_M;
          owner_d  = req_core_i;
          sharer_d = 1'b0;
        end else if (is_gets) begin
          if (sharer_q) begin
            state_d = BLK_S;
          end else begin
            // exclusive grant: reader may upgrade silently
            state_d = BLK_M;
            owner_d = req_core_i;
          end
        end
      end
      BLK_M: begin
        if (is_getm) begin
          owner_d  = req_core_i;
          sharer_d = 1'b0;
        end else if (is_gets) begin
          state_d = BLK_IORS_D;
        end else if (is_putm && (req_core_i == owner_q)) begin
          state_d = BLK_MI_D;
        end
      end
      BLK_IORS_D: begin
        if (wb_take_o) begin
          state_d  = BLK_S;
          sharer_d = 1'b1;
        end
      end
      BLK_MI_D: begin
        if (wb_take_o) state_d = BLK_I;
      end
      default: state_d = BLK_I;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= BLK_I;
      owner_q  <= '0;
      sharer_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      owner_q  <= owner_d;
      sharer_q <= sharer_d;
    end
  end

  // R5
  getm_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_getm && !waiting_o) |=> (state_q == BLK_M) && (owner_q == $past(req_core_i)) && !sharer_q);

  // R4
  downgrade_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BLK_IORS_D && wb_hit_i && wb_core_i == owner_q) |=> (state_q == BLK_S) && sharer_q);

  // R6
  evict_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BLK_M && is_putm && req_core_i == owner_q) |=> (state_q == BLK_MI_D));

  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o && !wb_take_o) |=> $stable(state_q) && $stable(owner_q) && $stable(sharer_q));
endmodule

// File: rtl/llc_snoop_store.sv
module llc_snoop_store #(
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 512,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [DATA_W-1:0] mem_q [NUM_BLOCKS];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BLOCKS; i++) mem_q[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
      rd_q <= mem_q[rd_addr_i];
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/llc_snoop_ctrl.sv
module llc_snoop_ctrl
  import llc_snoop_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int NUM_BLOCKS  = 8,
  parameter int BLOCK_BYTES = 64,
  localparam int CORE_W     = $clog2(NUM_CORES),
  localparam int ADDR_W     = $clog2(NUM_BLOCKS),
  localparam int DATA_W     = BLOCK_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_type_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              wb_valid_i,
  input  logic [CORE_W-1:0] wb_core_i,
  input  logic [ADDR_W-1:0] wb_addr_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic              resp_valid_o,
  output logic [CORE_W-1:0] resp_core_o,
  output logic [ADDR_W-1:0] resp_addr_o,
  output logic              resp_excl_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              sharer_present_o
);
  bus_req_e                req_type;
  logic [NUM_BLOCKS-1:0]   req_hit, wb_hit, respond, excl, sharer, take, waiting;
  logic                    resp_valid_q, resp_excl_q;
  logic [CORE_W-1:0]       resp_core_q;
  logic [ADDR_W-1:0]       resp_addr_q;

  assign req_type = bus_req_e'(req_type_i);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign req_hit[b] = req_valid_i && (req_addr_i == ADDR_W'(b)) && (req_type != REQ_RSVD);
    assign wb_hit[b]  = wb_valid_i && (wb_addr_i == ADDR_W'(b));

    llc_snoop_blk #(.CORE_W(CORE_W)) u_blk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_hit_i  (req_hit[b]),
      .req_type_i (req_type),
      .req_core_i (req_core_i),
      .wb_hit_i   (wb_hit[b]),
      .wb_core_i  (wb_core_i),
      .respond_o  (respond[b]),
      .excl_o     (excl[b]),
      .sharer_o   (sharer[b]),
      .wb_take_o  (take[b]),
      .waiting_o  (waiting[b])
    );
  end

  llc_snoop_store #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (req_addr_i),
    .rd_data_o (resp_data_o),
    .wr_en_i   (|take),
    .wr_addr_i (wb_addr_i),
    .wr_data_i (wb_data_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_q <= 1'b0;
      resp_excl_q  <= 1'b0;
      resp_core_q  <= '0;
      resp_addr_q  <= '0;
    end else begin
      resp_valid_q <= |respond;
      resp_excl_q  <= excl[req_addr_i];
      resp_core_q  <= req_core_i;
      resp_addr_q  <= req_addr_i;
    end
  end

  assign resp_valid_o     = resp_valid_q;
  assign resp_excl_o      = resp_excl_q;
  assign resp_core_o      = resp_core_q;
  assign resp_addr_o      = resp_addr_q;
  assign sharer_present_o = sharer[req_addr_i];

  // R2
  resp_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(req_valid_i));

  // R9
  single_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));

  // R8
  waiting_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && waiting[req_addr_i]) |=> !resp_valid_o);
endmodule

// File: tb/llc_snoop_ctrl_tb_top.sv
module llc_snoop_ctrl_tb_top;
  localparam int DW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_type = 2'b00;
  logic [1:0]    req_core = '0;
  logic [2:0]    req_addr = '0;
  logic          wb_valid = 1'b0;
  logic [1:0]    wb_core = '0;
  logic [2:0]    wb_addr = '0;
  logic [DW-1:0] wb_data = '0;
  logic          resp_valid, resp_excl, sharer_present;
  logic [1:0]    resp_core;
  logic [2:0]    resp_addr;
  logic [DW-1:0] resp_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  llc_snoop_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_type_i(req_type), .req_core_i(req_core), .req_addr_i(req_addr),
    .wb_valid_i(wb_valid), .wb_core_i(wb_core), .wb_addr_i(wb_addr), .wb_data_i(wb_data),
    .resp_valid_o(resp_valid), .resp_core_o(resp_core), .resp_addr_o(resp_addr),
    .resp_excl_o(resp_excl), .resp_data_o(resp_data), .sharer_present_o(sharer_present)
  );

  function automatic logic [DW-1:0] pat(input logic [31:0] seed);
    logic [DW-1:0] v;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = seed ^ (32'h01010101 * i);
    return v;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // drives one request cycle; outputs are sampled at the following negedge
  task automatic bus_req(input logic [1:0] t, input logic [1:0] c, input logic [2:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_core = c; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_wb(input logic [1:0] c, input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wb_valid = 1'b1; wb_core = c; wb_addr = a; wb_data = d;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic expect_resp(input string tag, input logic [1:0] c, input logic [2:0] a,
                             input logic ex, input logic [DW-1:0] d);
    checks++;
    if (resp_valid !== 1'b1 || resp_core !== c || resp_addr !== a || resp_excl !== ex || resp_data !== d) begin
      errors++;
      $display("FAIL %s: actual v=%0b core=%0d addr=%0d excl=%0b data=%h expected v=1 core=%0d addr=%0d excl=%0b data=%h",
               tag, resp_valid, resp_core, resp_addr, resp_excl, resp_data[31:0], c, a, ex, d[31:0]);
    end
  endtask

  task automatic flag_of(input string tag, input logic [2:0] a, input logic exp);
    @(negedge clk);
    req_addr = a;
    #1;
    check_bit(tag, sharer_present, exp);
  endtask

  task automatic t_reset;
    check_bit("R1 no response after reset", resp_valid, 1'b0);
    flag_of("R1 flag clear after reset", 3'd0, 1'b0);
  endtask

  task automatic t_excl_read;
    bus_req(2'b00, 2'd1, 3'd0);
    expect_resp("R3 R2 first read exclusive, zero data", 2'd1, 3'd0, 1'b1, '0);
  endtask

  task automatic t_downgrade;
    bus_req(2'b00, 2'd2, 3'd0);
    check_bit("R4 read to owned block unanswered", resp_valid, 1'b0);
    send_wb(2'd3, 3'd0, pat(32'hdead0000));
    send_wb(2'd1, 3'd0, pat(32'haaaa5555));
    flag_of("R4 R10 flag set after downgrade", 3'd0, 1'b1);
    bus_req(2'b00, 2'd3, 3'd0);
    expect_resp("R4 R9 R3 shared read returns owner data", 2'd3, 3'd0, 1'b0, pat(32'haaaa5555));
  endtask

  task automatic t_write_evict;
    bus_req(2'b01, 2'd2, 3'd0);
    expect_resp("R5 write from shared", 2'd2, 3'd0, 1'b1, pat(32'haaaa5555));
    flag_of("R5 R10 flag cleared by write", 3'd0, 1'b0);
    bus_req(2'b01, 2'd3, 3'd0);
    check_bit("R5 write to owned block unanswered", resp_valid, 1'b0);
    bus_req(2'b10, 2'd2, 3'd0);
    send_wb(2'd2, 3'd0, pat(32'h0badf00d));
    bus_req(2'b10, 2'd3, 3'd0);
    bus_req(2'b00, 2'd0, 3'd0);
    check_bit("R8 request during wait dropped", resp_valid, 1'b0);
    send_wb(2'd3, 3'd0, pat(32'h12345678));
    bus_req(2'b00, 2'd0, 3'd0);
    expect_resp("R6 R7 R8 evicted data returned exclusive", 2'd0, 3'd0, 1'b1, pat(32'h12345678));
  endtask

  task automatic t_ignored;
    bus_req(2'b10, 2'd1, 3'd6);
    bus_req(2'b11, 2'd1, 3'd6);
    check_bit("R7 reserved type unanswered", resp_valid, 1'b0);
    send_wb(2'd1, 3'd6, pat(32'hffff0000));
    bus_req(2'b00, 2'd2, 3'd6);
    expect_resp("R7 R9 stray eviction/writeback ignored", 2'd2, 3'd6, 1'b1, '0);
  endtask

  task automatic t_independent;
    bus_req(2'b01, 2'd1, 3'd5);
    expect_resp("R11 other block answered", 2'd1, 3'd5, 1'b1, '0);
    bus_req(2'b10, 2'd1, 3'd5);
    send_wb(2'd1, 3'd5, pat(32'h55550005));
    bus_req(2'b00, 2'd3, 3'd3);
    expect_resp("R11 untouched block still zero", 2'd3, 3'd3, 1'b1, '0);
    bus_req(2'b00, 2'd2, 3'd5);
    expect_resp("R11 R6 block 5 data", 2'd2, 3'd5, 1'b1, pat(32'h55550005));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_bit("R1 no response in reset", resp_valid, 1'b0);
    rst_n = 1'b1;
    t_reset();
    t_excl_read();
    t_downgrade();
    t_write_evict();
    t_ignored();
    t_independent();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule